// File: doc/BRIEF.md
# Blink Phase Timer with Load Synchronisation

This block decides when a multiplexed LED display should be blanked so that the whole display flashes. When blinking is enabled, it counts scan-oscillator ticks and toggles between a lit half-period and a dark half-period. There are two rates: the slow rate has half-periods twice as long as the fast rate. A start bit picks whether the first half-period after enabling is lit or dark.

Several drivers in a chain can be brought into step. When the sync bit is set, every rising edge of the shared load strobe does three things:

- it clears the blink counter,
- it restarts the blink phase,
- it sends a one-cycle clear pulse to the scan multiplexer.

The `blank_req` output goes to the scan block, which turns all segments off while the request is high. When blinking is disabled, the request stays low.

The block runs on the system clock. The oscillator is represented by a one-cycle `osc_tick` strobe, and the load edge by a one-cycle `load_rise` strobe. The fast half-period length in ticks is a parameter, so simulation can use short periods.

Top module: `blink_phase_timer`

## Requirements
- R1: During and directly after reset, `blank_req` and `mux_clr` are both 0, because every blink control defaults to 0.
- R2: When `blink_en` is 0, `blank_req` is 0 one cycle later, whatever the ticks and load strobes are doing.
- R3: In the cycle after `blink_en` rises, the counter restarts from zero and the phase equals `start_lit`. A value of 1 means lit, so `blank_req` is 0; a value of 0 means dark, so `blank_req` is 1.
- R4: With `rate_slow` = 0, the phase toggles on the HALF_FAST_TICKS-th tick counted from the start of each half-period.
- R5: With `rate_slow` = 1, each half-period lasts 2*HALF_FAST_TICKS ticks, and the internal count never reaches that value.
- R6: Over a whole number of periods, the dark time equals the lit time (50% duty).
- R7: With `sync_en` = 1, a `load_rise` pulse clears the counter and restarts the phase at `start_lit`, visible on the next cycle. A tick in that same cycle is not counted.
- R8: With `sync_en` = 0, a `load_rise` pulse does not change the phase or the count, and `mux_clr` stays 0.
- R9: With `sync_en` = 1, `mux_clr` is high for exactly one cycle, in the cycle after each `load_rise` pulse.
- R10: If the rate is lowered while the count already meets or exceeds the new half-period length, the half-period ends at the next tick.
- R11: Cycles without `osc_tick` change neither the count nor the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe at the scan oscillator rate |
| blink_en | input | 1 | Enables blinking |
| rate_slow | input | 1 | 0: fast half-period, 1: doubled half-period |
| sync_en | input | 1 | Lets the load edge restart blink and multiplex timing |
| start_lit | input | 1 | Phase after a restart: 1 lit, 0 dark |
| load_rise | input | 1 | One-cycle pulse marking a rising load/chip-select edge |
| blank_req | output | 1 | High when the display must be blanked |
| mux_clr | output | 1 | One-cycle clear request to the scan multiplex counter |

## Verification
Every result of this block appears exactly one clock edge after the inputs that cause it:

- a tick that ends a half-period,
- the enable edge,
- a synchronising load pulse,
- a change of `blink_en`.

For each driven cycle, the bench computes the expected `blank_req` and `mux_clr` from its own tick and phase bookkeeping. It queues these values before the edge, and a monitor compares them 5 ns after that edge. Because of this, every comparison lands in the single cycle that follows its stimulus. A 16-cycle window is also counted separately to confirm equal lit and dark time.

// File: rtl/blink_pkg.sv
`timescale 1ns/1ps
package blink_pkg;

  // Ticks in one half-period for the chosen rate.
  function automatic int unsigned half_len(input logic slow, input int unsigned fast_half);
    return slow ? (2 * fast_half) : fast_half;
  endfunction

  // Counter width able to hold the slow half-period length.
  function automatic int unsigned cnt_width(input int unsigned fast_half);
    return $clog2(2 * fast_half + 1);
  endfunction

endpackage

// File: rtl/blink_restart.sv
`timescale 1ns/1ps
module blink_restart (
  input  logic clk,
  input  logic rst_n,
  input  logic blink_en,
  input  logic sync_en,
  input  logic load_rise,
  output logic restart,
  output logic en_q,
  output logic mux_clr
);
  logic sync_hit;

  assign sync_hit = sync_en & load_rise;
  assign restart  = (blink_en & ~en_q) | sync_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mux_clr <= 1'b0;
    end else begin
      en_q    <= blink_en;
      mux_clr <= sync_hit;
    end
  end
endmodule

// File: rtl/blink_half_cnt.sv
`timescale 1ns/1ps
module blink_half_cnt #(
  parameter int unsigned HALF_FAST_TICKS = 800,
  parameter int unsigned CNT_W           = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic             slow,
  output logic [CNT_W-1:0] cnt,
  output logic             half_done
);
  logic [CNT_W-1:0] limit;
  logic             last;

  always_comb begin
    limit     = CNT_W'(blink_pkg::half_len(slow, HALF_FAST_TICKS));
    last      = (cnt >= (limit - CNT_W'(1)));
    half_done = run & tick & ~restart & last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/blink_phase.sv
`timescale 1ns/1ps
module blink_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic start_lit,
  input  logic half_done,
  output logic phase_on
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_on <= 1'b0;
    end else if (restart) begin
      phase_on <= start_lit;
    end else if (half_done) begin
      phase_on <= ~phase_on;
    end
  end
endmodule

// File: rtl/blink_phase_timer.sv
`timescale 1ns/1ps
module blink_phase_timer #(
  parameter int unsigned HALF_FAST_TICKS = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic blink_en,
  input  logic rate_slow,
  input  logic sync_en,
  input  logic start_lit,
  input  logic load_rise,
  output logic blank_req,
  output logic mux_clr
);
  localparam int unsigned CNT_W = blink_pkg::cnt_width(HALF_FAST_TICKS);

  // Named internal events, visible to the bound checker.
  logic             restart;
  logic             en_q;
  logic             half_done;
  logic             phase_on;
  logic [CNT_W-1:0] cnt;

  blink_restart u_restart (
    .clk       (clk),
    .rst_n     (rst_n),
    .blink_en  (blink_en),
    .sync_en   (sync_en),
    .load_rise (load_rise),
    .restart   (restart),
    .en_q      (en_q),
    .mux_clr   (mux_clr)
  );

  blink_half_cnt #(
    .HALF_FAST_TICKS (HALF_FAST_TICKS),
    .CNT_W           (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .run       (blink_en),
    .tick      (osc_tick),
    .slow      (rate_slow),
    .cnt       (cnt),
    .half_done (half_done)
  );

  blink_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .start_lit (start_lit),
    .half_done (half_done),
    .phase_on  (phase_on)
  );

  assign blank_req = en_q & ~phase_on;
endmodule

// File: rtl/blink_phase_timer_chk.sv
`timescale 1ns/1ps
module blink_phase_timer_chk #(
  parameter int unsigned HALF_FAST_TICKS = 800,
  parameter int unsigned CNT_W           = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blink_en,
  input logic             sync_en,
  input logic             start_lit,
  input logic             load_rise,
  input logic             blank_req,
  input logic             mux_clr,
  input logic             restart,
  input logic             half_done,
  input logic             phase_on,
  input logic [CNT_W-1:0] cnt
);
  p_dark_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_en |=> !blank_req);

  p_start_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_en && restart) |=> (blank_req == !$past(start_lit)));

  p_half_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |=> (phase_on != $past(phase_on)));

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(2 * HALF_FAST_TICKS));

  p_sync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && load_rise) |=> (cnt == '0));

  p_no_mux_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_en && load_rise) |=> !mux_clr);

  p_mux_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && load_rise) |=> mux_clr);

  p_phase_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_done && !restart) |=> $stable(phase_on));
endmodule

bind blink_phase_timer blink_phase_timer_chk #(
  .HALF_FAST_TICKS (HALF_FAST_TICKS),
  .CNT_W           (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .blink_en  (blink_en),
  .sync_en   (sync_en),
  .start_lit (start_lit),
  .load_rise (load_rise),
  .blank_req (blank_req),
  .mux_clr   (mux_clr),
  .restart   (restart),
  .half_done (half_done),
  .phase_on  (phase_on),
  .cnt       (cnt)
);

// File: tb/blink_phase_timer_bench.sv
`timescale 1ns/1ps
module blink_phase_timer_bench;
  localparam int unsigned HALF = 4;

  typedef struct {
    logic  blank;
    logic  mux;
    string req;
    bit    duty;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, blink_en = 1'b0, rate_slow = 1'b0;
  logic sync_en = 1'b0, start_lit = 1'b0, load_rise = 1'b0;
  logic blank_req, mux_clr;

  item_t exp_q[$];
  int checks = 0, fails = 0;
  int duty_dark = 0, duty_lit = 0;

  // Bench-side bookkeeping of the blink state.
  logic m_en = 1'b0, m_on = 1'b0;
  int   m_since = 0;

  always #10 clk = ~clk;

  blink_phase_timer #(.HALF_FAST_TICKS(HALF)) u_blink_phase_timer (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .blink_en(blink_en),
    .rate_slow(rate_slow), .sync_en(sync_en), .start_lit(start_lit),
    .load_rise(load_rise), .blank_req(blank_req), .mux_clr(mux_clr)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the result due after the edge.
  task automatic step(input logic tk, input logic ld, input string req, input bit duty = 0);
    item_t it;
    int    half;
    bit    rs;
    osc_tick  = tk;
    load_rise = ld;
    half = rate_slow ? 2 * HALF : HALF;
    rs   = (blink_en && !m_en) || (sync_en && ld);
    if (rs) begin
      m_since = 0;
      m_on    = start_lit;
    end else if (!blink_en) begin
      m_since = 0;
    end else if (tk) begin
      m_since = m_since + 1;
      if (m_since >= half) begin
        m_on    = !m_on;
        m_since = 0;
      end
    end
    m_en = blink_en;
    it.blank = m_en && !m_on;
    it.mux   = sync_en && ld;
    it.req   = req;
    it.duty  = duty;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compares 5 ns after each rising edge.
  always begin
    item_t it;
    @(posedge clk);
    #5;
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      chk(blank_req === it.blank, it.req, "blank_req", int'(blank_req), int'(it.blank));
      chk(mux_clr === it.mux, it.req, "mux_clr", int'(mux_clr), int'(it.mux));
      if (it.duty) begin
        if (blank_req) duty_dark++;
        else duty_lit++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(blank_req === 1'b0, "R1", "blank_req in reset", int'(blank_req), 0);
    chk(mux_clr === 1'b0, "R1", "mux_clr in reset", int'(mux_clr), 0);
    rst_n = 1'b1;
    step(0, 0, "R1");

    // R2: disabled, ticks and loads do nothing to blanking
    for (int i = 0; i < 10; i++) step(1, i == 5, "R2");

    // R3/R4: fast rate, start dark
    start_lit = 1'b0; blink_en = 1'b1;
    step(1, 0, "R3");
    for (int i = 0; i < 20; i++) step(1, 0, "R4");
    blink_en = 1'b0;
    step(0, 0, "R2");
    step(1, 0, "R2");

    // R3: start lit, ticks spaced out
    start_lit = 1'b1; blink_en = 1'b1;
    step(0, 0, "R3");
    for (int i = 0; i < 12; i++) begin
      step(1, 0, "R3");
      step(0, 0, "R3");
    end
    blink_en = 1'b0;
    step(0, 0, "R2");

    // R5: slow rate
    rate_slow = 1'b1; start_lit = 1'b0; blink_en = 1'b1;
    step(1, 0, "R5");
    for (int i = 0; i < 34; i++) step(1, 0, "R5");
    blink_en = 1'b0;
    step(0, 0, "R2");

    // R6: duty over two full fast periods
    rate_slow = 1'b0; start_lit = 1'b0; blink_en = 1'b1;
    for (int i = 0; i < 16; i++) step(1, 0, "R6", 1);

    // R11: no ticks, nothing moves
    for (int i = 0; i < 10; i++) step(0, 0, "R11");

    // R7/R9: sync restarts mid-phase and pulses the multiplex clear
    sync_en = 1'b1; start_lit = 1'b1;
    for (int i = 0; i < 6; i++) step(1, 0, "R7");
    step(1, 1, "R7");
    for (int i = 0; i < 9; i++) step(1, 0, "R7");
    step(0, 1, "R9");
    step(0, 0, "R9");

    // R8: load without sync is ignored
    sync_en = 1'b0;
    step(1, 1, "R8");
    step(1, 0, "R8");
    step(1, 1, "R8");
    for (int i = 0; i < 6; i++) step(1, 0, "R8");

    // R10: drop to fast rate with the count past the new limit
    blink_en = 1'b0;
    step(0, 0, "R2");
    rate_slow = 1'b1; start_lit = 1'b0; blink_en = 1'b1;
    step(0, 0, "R10");
    for (int i = 0; i < 6; i++) step(1, 0, "R10");
    rate_slow = 1'b0;
    step(1, 0, "R10");
    for (int i = 0; i < 8; i++) step(1, 0, "R10");

    blink_en = 1'b0;
    step(0, 0, "R2");
    step(0, 0, "R2");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);

    chk(duty_dark == 8, "R6", "dark cycles", duty_dark, 8);
    chk(duty_lit == 8, "R6", "lit cycles", duty_lit, 8);

    summary();
    $finish;
  end
endmodule